// File: doc/BRIEF.md
# Banked Shared Memory Conflict Arbiter

This block sits between a group of threads and a scratch memory built from equal banks that can all be accessed in the same cycle, each bank accepting one access per cycle. A request carries one word address per thread and an active mask. The block replays the request over as many back-to-back passes as the worst bank needs. In each pass every bank is driven with at most one word address. Every pending thread that wants that word is granted in the same pass, so identical addresses are broadcast and do not cost extra passes.

The bank of a word is given by its low address bits. Within a bank, the order of service follows thread numbers: the word asked for by the lowest-numbered pending thread goes first. The block raises a completion strobe in the final pass. It takes no new request until the current one has finished.

Top module: `sm_bank_arbiter`

## Requirements
- R1: After reset, req_ready is 1 and bank_en, thr_grant and done are all 0.
- R2: A request is taken at a clock edge where req_valid and req_ready are both 1. From the next cycle until the cycle that shows done, req_ready is 0, and the request inputs during that time have no effect.
- R3: The bank of a thread is the low log2(NBANK) bits of its word address, which is bits [AW-1:0] of slice t of req_addr. NBANK is a power of two of at least 2.
- R4: In each pass, each bank has bank_en set only if a pending thread maps to it. Its bank_addr slice then carries the address of the lowest-numbered pending thread in that bank.
- R5: Every pending thread whose address equals the word its bank serves in a pass is granted in that pass (broadcast).
- R6: Each thread whose mask bit is 1 is granted in exactly one pass. A thread whose mask bit is 0 is never granted.
- R7: The first pass is in the cycle after acceptance. The number of passes equals the largest count of distinct addresses among active threads in any one bank, and done is 1 only in the last pass.
- R8: A request with an all-zero mask takes one pass, with done set and no grants or bank enables.
- R9: req_ready is 1 again in the cycle after the one that shows done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | NTHR*AW | Word address per thread, thread t in slice t |
| req_mask | input | NTHR | Active thread mask |
| bank_en | output | NBANK | Bank access enable for the current pass |
| bank_addr | output | NBANK*AW | Word address per bank, bank b in slice b |
| thr_grant | output | NTHR | Threads served in the current pass |
| done | output | 1 | Current pass is the last one of the request |

## Verification
The pass outputs are decoded from registered state. Pass k of a request is therefore visible in the (k+1)-th cycle after the accepting edge, and req_ready returns one cycle after done. The bench drives inputs and samples outputs at the falling edge. It accepts at one rising edge, compares the first pass at the next falling edge, and then steps one cycle per expected pass. Every request in a small configuration (four threads, two banks, two-bit addresses, every mask) is replayed this way. The expected pass of each thread is computed from its address's rank of first appearance in its bank. While the block is busy, inverted request data is held on the inputs.

// File: rtl/sm_arb_pkg.sv
package sm_arb_pkg;
    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_SERVE = 1'b1
    } arb_state_e;
endpackage

// File: rtl/sm_bank_pick.sv
// Selects the word one bank serves: the address of the lowest-numbered
// pending thread whose address maps to this bank.
module sm_bank_pick #(
    parameter int NTHR    = 8,
    parameter int AW      = 10,
    parameter int BW      = 2,
    parameter int BANK_ID = 0
) (
    input  logic [NTHR*AW-1:0] addr_flat,
    input  logic [NTHR-1:0]    pend,
    output logic               hit,
    output logic [AW-1:0]      lead_addr
);
    always_comb begin
        hit       = 1'b0;
        lead_addr = '0;
        // descending scan: the lowest index written last wins
        for (int t = NTHR - 1; t >= 0; t--) begin
            if (pend[t] && (addr_flat[t*AW +: BW] == BW'(BANK_ID))) begin
                hit       = 1'b1;
                lead_addr = addr_flat[t*AW +: AW];
            end
        end
    end
endmodule

// File: rtl/sm_thread_match.sv
// A thread is served when its bank is active on exactly its word.
module sm_thread_match #(
    parameter int NBANK = 4,
    parameter int AW    = 10,
    parameter int BW    = 2
) (
    input  logic [AW-1:0]       my_addr,
    input  logic                my_pend,
    input  logic [NBANK-1:0]    bank_en,
    input  logic [NBANK*AW-1:0] bank_addr,
    output logic                grant
);
    logic [BW-1:0] sel;

    always_comb begin
        sel   = my_addr[BW-1:0];
        grant = my_pend && bank_en[sel] && (bank_addr[sel*AW +: AW] == my_addr);
    end
endmodule

// File: rtl/sm_bank_arbiter.sv
module sm_bank_arbiter
    import sm_arb_pkg::*;
#(
    parameter int NTHR  = 8,
    parameter int NBANK = 4,   // power of two, at least 2
    parameter int AW    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [NTHR*AW-1:0]  req_addr,
    input  logic [NTHR-1:0]     req_mask,
    output logic [NBANK-1:0]    bank_en,
    output logic [NBANK*AW-1:0] bank_addr,
    output logic [NTHR-1:0]     thr_grant,
    output logic                done
);
    localparam int BW = $clog2(NBANK);

    typedef struct packed {
        arb_state_e         st;
        logic [NTHR-1:0]    pend;
        logic [NTHR*AW-1:0] addr;
    } arb_t;

    arb_t st_d, st_q;

    logic [NBANK-1:0]    hit_w;
    logic [NBANK*AW-1:0] lead_w;
    logic [NTHR-1:0]     grant_w;

    // one picker per bank
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sm_bank_pick #(
            .NTHR(NTHR), .AW(AW), .BW(BW), .BANK_ID(b)
        ) u_pick (
            .addr_flat (st_q.addr),
            .pend      (st_q.pend),
            .hit       (hit_w[b]),
            .lead_addr (lead_w[b*AW +: AW])
        );
    end

    // one matcher per thread
    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        sm_thread_match #(
            .NBANK(NBANK), .AW(AW), .BW(BW)
        ) u_match (
            .my_addr   (st_q.addr[t*AW +: AW]),
            .my_pend   (st_q.pend[t]),
            .bank_en   (hit_w),
            .bank_addr (lead_w),
            .grant     (grant_w[t])
        );
    end

    always_comb begin
        st_d      = st_q;
        req_ready = (st_q.st == ARB_IDLE);
        bank_en   = hit_w;
        bank_addr = lead_w;
        thr_grant = grant_w;
        done      = (st_q.st == ARB_SERVE) && ((st_q.pend & ~grant_w) == '0);

        if (st_q.st == ARB_IDLE) begin
            if (req_valid) begin
                st_d.st   = ARB_SERVE;
                st_d.pend = req_mask;
                st_d.addr = req_addr;
            end
        end else begin
            st_d.pend = st_q.pend & ~grant_w;
            if (done) begin
                st_d.st = ARB_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: ARB_IDLE, pend: '0, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sm_bank_arbiter_chk.sv
module sm_bank_arbiter_chk #(
    parameter int NTHR  = 8,
    parameter int NBANK = 4,
    parameter int AW    = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [NTHR*AW-1:0]  req_addr,
    input logic [NTHR-1:0]     req_mask,
    input logic [NBANK-1:0]    bank_en,
    input logic [NBANK*AW-1:0] bank_addr,
    input logic [NTHR-1:0]     thr_grant,
    input logic                done
);
    localparam int BW = $clog2(NBANK);

    logic [NTHR-1:0]    mask_lat;
    logic [NTHR-1:0]    seen;
    logic [NTHR*AW-1:0] addr_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_lat <= '0;
            addr_lat <= '0;
            seen     <= '0;
        end else if (req_valid && req_ready) begin
            mask_lat <= req_mask;
            addr_lat <= req_addr;
            seen     <= '0;
        end else begin
            seen <= seen | thr_grant;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (thr_grant == '0 && bank_en == '0 && !done));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R6
    grant_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_grant & ~mask_lat) == '0);

    // R6
    grant_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_grant & seen) == '0);

    // R7
    done_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((seen | thr_grant) == mask_lat));

    // R9
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    for (genvar t = 0; t < NTHR; t++) begin : g_route
        logic [BW-1:0] bsel;
        assign bsel = addr_lat[t*AW +: BW];
        // R4
        grant_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
            thr_grant[t] |-> (bank_en[bsel] &&
                              bank_addr[bsel*AW +: AW] == addr_lat[t*AW +: AW]));
    end
endmodule

bind sm_bank_arbiter sm_bank_arbiter_chk #(
    .NTHR(NTHR), .NBANK(NBANK), .AW(AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .bank_en(bank_en),
    .bank_addr(bank_addr), .thr_grant(thr_grant), .done(done)
);

// File: tb/sm_bank_arbiter_bench.sv
module sm_bank_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int NB = 2;
    localparam int AWB = 2;
    localparam int WATCHDOG = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [NT*AWB-1:0] req_addr = '0;
    logic [NT-1:0]     req_mask = '0;
    logic [NB-1:0]     bank_en;
    logic [NB*AWB-1:0] bank_addr;
    logic [NT-1:0]     thr_grant;
    logic              done;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sm_bank_arbiter #(.NTHR(NT), .NBANK(NB), .AW(AWB)) u_sm_bank_arbiter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .bank_en(bank_en),
        .bank_addr(bank_addr), .thr_grant(thr_grant), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_req(input logic [NT*AWB-1:0] av, input logic [NT-1:0] mv);
        int first[NT];
        int rank[NT];
        int npass;
        logic [NT-1:0]     eg;
        logic [NB-1:0]     ee;
        logic [NB*AWB-1:0] ea;
        // first active thread sharing each thread's address
        for (int t = 0; t < NT; t++) begin
            first[t] = t;
            for (int u = NT - 1; u >= 0; u--)
                if (mv[u] && u <= t && av[u*AWB +: AWB] == av[t*AWB +: AWB]) first[t] = u;
        end
        npass = 1;
        for (int t = 0; t < NT; t++) begin
            rank[t] = 0;
            for (int u = 0; u < NT; u++)
                if (mv[u] && first[u] == u && u < first[t] &&
                    av[u*AWB] == av[t*AWB]) rank[t]++;
            if (mv[t] && rank[t] + 1 > npass) npass = rank[t] + 1;
        end

        // R9 / R2: idle at start of a request
        chk(req_ready == 1'b1, "R9", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = av;
        req_mask  = mv;
        @(posedge clk);
        for (int p = 0; p < npass; p++) begin
            @(negedge clk);
            // R2: garbage while busy must not matter
            req_addr = ~av;
            req_mask = ~mv;
            eg = '0; ee = '0; ea = '0;
            for (int t = 0; t < NT; t++) begin
                if (mv[t] && rank[t] == p) begin
                    eg[t] = 1'b1;
                    ee[av[t*AWB]] = 1'b1;               // R3: bank = low bit
                    ea[av[t*AWB]*AWB +: AWB] = av[t*AWB +: AWB];
                end
            end
            chk(req_ready == 1'b0, "R2", int'(req_ready), 0);
            chk(thr_grant == eg, (mv == '0) ? "R8" : "R5", int'(thr_grant), int'(eg));
            chk(bank_en == ee, "R4", int'(bank_en), int'(ee));
            chk((bank_addr & {{AWB{ee[1]}}, {AWB{ee[0]}}}) == ea, "R4",
                int'(bank_addr), int'(ea));
            chk(done == (p == npass - 1), "R7", int'(done), int'(p == npass - 1));
        end
        @(negedge clk);
        req_valid = 1'b0;
        // R6 / R7: no further pass beyond the expected count
        chk(thr_grant == '0 && !done, "R6", int'(thr_grant), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 2 + CLK_PERIOD / 4);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
        chk(bank_en == '0 && thr_grant == '0 && !done, "R1",
            int'({bank_en, thr_grant, done}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int code = 0; code < 4096; code++) begin
            run_req(code[11:4], code[3:0]);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule